// File: doc/BRIEF.md
# Mirror Block Command Sequencer

This block sits between a pattern source and the drive logic of a micromirror array of sixteen blocks. A strobe marks the start of each row cycle. With the strobe the block samples a two-bit command mode, a four-bit block address and a pair/quad select, and turns them into a one-cycle clear mask, a one-cycle pulse mask or a float request. Each mask has one bit per block.

The block also enforces the spacing rules around these commands:

- A mirror pulse or a float makes the array busy for a set time. That time only runs down while row cycles keep arriving.
- A clear must be followed by two no-op row cycles.
- Clears have no effect while the array loads four physical rows per data row.
- A command that arrives too early is dropped, and a sticky violation flag is set.

Every block has its own idle timer. When any timer reaches its limit, the block issues a global pulse on its own. All durations are parameters counted in clock cycles.

Top module: `mirror_blk_seq`

## Requirements
- R1: A row-start with mode 00 changes no output. The clear mask and the pulse mask stay 0 and the float request stays low.
- R2: A row-start with mode 01 and address A drives the clear mask to the one-hot value 1<<A, for exactly the next cycle.
- R3: A row-start with mode 10 and address A drives the pulse mask to 1<<A, for exactly the next cycle.
- R4: With mode 11 and address bit 3 low, the pair/quad select picks the group:
  - Select 0 pulses the two blocks 2P and 2P+1, where P is address bits [2:0].
  - Select 1 pulses the four blocks 4Q to 4Q+3, where Q is address bits [2:1].
- R5: Mode 11 with address bits [3:2]=10 pulses all 16 blocks. Mode 11 with address bits [3:2]=11 raises the float request and leaves the pulse mask 0.
- R6: An accepted pulse holds busy high for BUSY_CYC row-valid cycles. A pulse or float requested while busy is dropped.
- R7: An accepted float holds busy high for FLOAT_CYC row-valid cycles.
- R8: The busy count does not advance while row_valid is low, so busy cannot fall then.
- R9: After an accepted clear, the next two mode-00 row-starts must come before any other command. A non-no-op command inside that window is dropped.
- R10: While four_row_en is high, a clear command produces no clear mask. It also opens no spacing window and sets no violation.
- R11: Each block has its own idle timer, which restarts whenever that block's pulse-mask bit is set. When any timer reaches WD_CYC clocks after reset, a pulse mask of all ones follows on the next cycle.
- R12: While wdog_off is high, the idle timers are held at zero and no automatic pulse occurs.
- R13: Any dropped command sets `violation`. Once set, `violation` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | High while a row cycle (data or no-op) is in progress |
| row_start | input | 1 | One-cycle strobe marking the start of a row cycle; command inputs are sampled here |
| blk_mode | input | 2 | Command mode: 00 no-op, 01 clear, 10 single pulse, 11 group/global/float |
| blk_addr | input | 4 | Block address or group selector |
| quad_sel | input | 1 | For mode 11 groups: 0 selects pairs, 1 selects quads |
| four_row_en | input | 1 | Four-row load mode active; clears are ignored |
| wdog_off | input | 1 | Disables the idle watchdog |
| clear_mask | output | 16 | One-cycle mask of blocks to clear |
| pulse_mask | output | 16 | One-cycle mask of blocks to pulse |
| float_req | output | 1 | One-cycle request to float all blocks |
| busy | output | 1 | A pulse or float is still in progress |
| violation | output | 1 | Sticky flag: a command arrived too early and was dropped |

## Verification
Each kind of corrupted internal count shows up at the ports in a different way:

- A wrong busy count changes the number of cycles busy stays high after a pulse, so it is visible within one pulse duration. It also makes a follow-up pulse either pass or be rejected wrongly, which shows on the very next row-start.
- A corrupted spacing counter drops a legal clear or passes an early one. The masks and the violation flag show this one cycle after the offending row-start.
- A faulty idle timer moves the automatic all-ones pulse away from the cycle after WD_CYC.
- A faulty decode shows in the mask of the cycle right after the strobe.

// File: rtl/mirror_blk_seq.sv
module mirror_blk_seq #(
  parameter int BUSY_CYC  = 400,
  parameter int FLOAT_CYC = 30000,
  parameter int WD_CYC    = 1000000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        row_valid,
  input  logic        row_start,
  input  logic [1:0]  blk_mode,
  input  logic [3:0]  blk_addr,
  input  logic        quad_sel,
  input  logic        four_row_en,
  input  logic        wdog_off,
  output logic [15:0] clear_mask,
  output logic [15:0] pulse_mask,
  output logic        float_req,
  output logic        busy,
  output logic        violation
);
  localparam int NBLK = 16;
  localparam int BMAX = (FLOAT_CYC > BUSY_CYC) ? FLOAT_CYC : BUSY_CYC;
  localparam int BW   = $clog2(BMAX + 1);
  localparam int WW   = $clog2(WD_CYC + 1);

  logic [BW-1:0]   bcnt;
  logic [1:0]      gap;
  logic [NBLK-1:0] wd_exp;

  wire is_noop = (blk_mode == 2'b00);
  wire is_clr  = (blk_mode == 2'b01);
  wire is_pls  = blk_mode[1];
  wire is_flt  = (blk_mode == 2'b11) && (blk_addr[3:2] == 2'b11);

  wire [NBLK-1:0] one_hot = 16'h0001 << blk_addr;
  wire [NBLK-1:0] grp     = quad_sel ? (16'h000F << {blk_addr[2:1], 2'b00})
                                     : (16'h0003 << {blk_addr[2:0], 1'b0});
  wire [NBLK-1:0] pmask   = (blk_mode == 2'b10) ? one_hot :
                            blk_addr[3]         ? {NBLK{1'b1}} : grp;

  assign busy = (bcnt != '0);
  wire in_gap  = (gap != 2'd0);
  wire clr_ign = is_clr && four_row_en;
  wire clr_ok  = row_start && is_clr && !four_row_en && !in_gap;
  wire pls_ok  = row_start && is_pls && !busy && !in_gap;
  wire early   = row_start && !is_noop && !clr_ign && (in_gap || (is_pls && busy));
  wire wd_fire = !wdog_off && (|wd_exp) && !busy && !in_gap && !pls_ok && !clr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_mask <= '0;
      pulse_mask <= '0;
      float_req  <= 1'b0;
      bcnt       <= '0;
      gap        <= 2'd0;
      violation  <= 1'b0;
    end else begin
      clear_mask <= clr_ok ? one_hot : '0;
      pulse_mask <= (pls_ok && !is_flt) ? pmask : wd_fire ? {NBLK{1'b1}} : '0;
      float_req  <= pls_ok && is_flt;
      violation  <= violation | early;
      if (pls_ok)
        bcnt <= is_flt ? BW'(FLOAT_CYC) : BW'(BUSY_CYC);
      else if (wd_fire)
        bcnt <= BW'(BUSY_CYC);
      else if (row_valid && busy)
        bcnt <= bcnt - 1'b1;
      if (clr_ok)
        gap <= 2'd2;
      else if (row_start && is_noop && in_gap)
        gap <= gap - 1'b1;
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_wd
    logic [WW-1:0] tmr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         tmr <= '0;
      else if (wdog_off || pulse_mask[i]) tmr <= '0;
      else if (tmr != WW'(WD_CYC))        tmr <= tmr + 1'b1;
    end
    assign wd_exp[i] = (tmr == WW'(WD_CYC));
  end

  a_r2_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clear_mask));
  a_r6_pulse_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_mask != '0) || float_req) |-> busy);
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !row_valid) |=> busy);
  a_r9_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_mask != '0) |-> (pulse_mask == '0) && !float_req);
  a_r10_no_clear_4row: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start && four_row_en) |=> (clear_mask == '0));
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
endmodule

// File: tb/mirror_blk_seq_tb.sv
module mirror_blk_seq_tb;
  localparam int BUSY = 6;
  localparam int FLT  = 12;
  localparam int WD   = 50;

  logic clk = 0, rst_n = 0, row_valid = 0, row_start = 0;
  logic [1:0] blk_mode = 0;
  logic [3:0] blk_addr = 0;
  logic quad_sel = 0, four_row_en = 0, wdog_off = 1;
  logic [15:0] clear_mask, pulse_mask;
  logic float_req, busy, violation;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mirror_blk_seq #(.BUSY_CYC(BUSY), .FLOAT_CYC(FLT), .WD_CYC(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_start(row_start),
    .blk_mode(blk_mode), .blk_addr(blk_addr), .quad_sel(quad_sel),
    .four_row_en(four_row_en), .wdog_off(wdog_off), .clear_mask(clear_mask),
    .pulse_mask(pulse_mask), .float_req(float_req), .busy(busy), .violation(violation));

  // mode, addr, qsel, exp clear, exp pulse, exp float
  localparam logic [39:0] VEC [0:12] = '{
    {2'b00, 4'd0,  1'b0, 16'h0000, 16'h0000, 1'b0},  // R1
    {2'b01, 4'd5,  1'b0, 16'h0020, 16'h0000, 1'b0},  // R2
    {2'b01, 4'd15, 1'b0, 16'h8000, 16'h0000, 1'b0},  // R2
    {2'b10, 4'd0,  1'b0, 16'h0000, 16'h0001, 1'b0},  // R3
    {2'b10, 4'd12, 1'b0, 16'h0000, 16'h1000, 1'b0},  // R3
    {2'b11, 4'd3,  1'b0, 16'h0000, 16'h00C0, 1'b0},  // R4 pair
    {2'b11, 4'd7,  1'b0, 16'h0000, 16'hC000, 1'b0},  // R4 pair
    {2'b11, 4'd0,  1'b0, 16'h0000, 16'h0003, 1'b0},  // R4 pair
    {2'b11, 4'd2,  1'b1, 16'h0000, 16'h00F0, 1'b0},  // R4 quad
    {2'b11, 4'd6,  1'b1, 16'h0000, 16'hF000, 1'b0},  // R4 quad
    {2'b11, 4'd8,  1'b0, 16'h0000, 16'hFFFF, 1'b0},  // R5 global
    {2'b11, 4'd11, 1'b1, 16'h0000, 16'hFFFF, 1'b0},  // R5 global
    {2'b11, 4'd12, 1'b0, 16'h0000, 16'h0000, 1'b1}   // R5 float
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic wd_off);
    @(negedge clk);
    rst_n = 0; row_start = 0; blk_mode = 0; blk_addr = 0; quad_sel = 0;
    four_row_en = 0; wdog_off = wd_off; row_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; row_valid = 1;
  endtask

  // starts at a negedge, returns at the negedge where the result is visible
  task automatic do_row(input logic [1:0] m, input logic [3:0] a, input logic q);
    blk_mode = m; blk_addr = a; quad_sel = q; row_start = 1;
    @(negedge clk);
    row_start = 0; blk_mode = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL timeout act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int first;
    do_reset(1);
    chk("R1 reset clear_mask", clear_mask, 0);
    chk("R1 reset pulse_mask", pulse_mask, 0);
    chk("R1 reset busy/float/viol", {busy, float_req, violation}, 0);

    for (int i = 0; i < 13; i++) begin
      do_row(VEC[i][39:38], VEC[i][37:34], VEC[i][33]);
      chk($sformatf("R1-5 vec%0d clear", i), clear_mask, VEC[i][32:17]);
      chk($sformatf("R1-5 vec%0d pulse", i), pulse_mask, VEC[i][16:1]);
      chk($sformatf("R5 vec%0d float", i), float_req, VEC[i][0]);
      @(negedge clk);
      chk($sformatf("R2 R3 vec%0d one-cycle", i), {clear_mask, pulse_mask, float_req}, 0);
      do_row(2'b00, 0, 0);
      do_row(2'b00, 0, 0);
      repeat (20) @(negedge clk);
    end
    chk("R13 no violation in legal table", violation, 0);

    // R6 busy length and rejection
    do_reset(1);
    do_row(2'b10, 4'd1, 0);
    chk("R6 pulse accepted", pulse_mask, 16'h0002);
    do_row(2'b10, 4'd2, 0);
    chk("R6 pulse while busy dropped", pulse_mask, 0);
    chk("R13 violation on busy pulse", violation, 1);
    do_row(2'b11, 4'd12, 0);
    chk("R6 float while busy dropped", float_req, 0);
    repeat (30) @(negedge clk);
    chk("R13 violation sticky", violation, 1);
    do_reset(1);
    do_row(2'b10, 4'd1, 0);
    count_busy(n);
    chk("R6 busy length", n, BUSY);

    // R7 float length
    do_row(2'b11, 4'd13, 0);
    chk("R7 float accepted", float_req, 1);
    count_busy(n);
    chk("R7 float busy length", n, FLT);

    // R8 busy frozen without row cycles
    do_row(2'b10, 4'd4, 0);
    row_valid = 0;
    repeat (25) @(negedge clk);
    chk("R8 busy held without rows", busy, 1);
    row_valid = 1;
    count_busy(n);
    chk("R8 busy resumes full count", n, BUSY);

    // R9 spacing
    do_reset(1);
    do_row(2'b01, 4'd3, 0);
    chk("R9 clear ok", clear_mask, 16'h0008);
    do_row(2'b10, 4'd0, 0);
    chk("R9 pulse in gap dropped", pulse_mask, 0);
    chk("R9 violation set", violation, 1);
    do_reset(1);
    do_row(2'b01, 4'd3, 0);
    do_row(2'b00, 0, 0);
    do_row(2'b01, 4'd4, 0);
    chk("R9 clear after one noop dropped", clear_mask, 0);
    chk("R9 violation after one noop", violation, 1);
    do_reset(1);
    do_row(2'b01, 4'd3, 0);
    do_row(2'b00, 0, 0);
    do_row(2'b00, 0, 0);
    do_row(2'b01, 4'd4, 0);
    chk("R9 clear after two noops", clear_mask, 16'h0010);
    chk("R9 no violation", violation, 0);

    // R10 four-row mode
    do_reset(1);
    four_row_en = 1;
    do_row(2'b01, 4'd2, 0);
    chk("R10 clear ignored", clear_mask, 0);
    do_row(2'b10, 4'd2, 0);
    chk("R10 no gap opened", pulse_mask, 16'h0004);
    chk("R10 no violation", violation, 0);
    four_row_en = 0;

    // R11 watchdog
    do_reset(0);
    first = 0;
    for (int i = 1; i <= WD + 5; i++) begin
      @(negedge clk);
      if (first == 0 && pulse_mask != 0) begin
        first = i;
        chk("R11 watchdog mask", pulse_mask, 16'hFFFF);
      end
    end
    chk("R11 watchdog timing", first, WD + 1);

    // R12 watchdog disabled
    do_reset(1);
    first = 0;
    for (int i = 1; i <= 2 * WD; i++) begin
      @(negedge clk);
      if (pulse_mask != 0) first = i;
    end
    chk("R12 no auto pulse when off", first, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule